// File: doc/BRIEF.md
# Remappable Bus Address Decoder

This block turns a 32-bit bus address into a one-hot choice of target: an on-chip 32 KB ROM, an on-chip 64 KB SRAM, or a 64 KB peripheral window. It also returns the address offset inside the chosen region. A remap input, driven by a control register outside the block, picks which memory sits at the bottom of the address space. With remap clear, the ROM answers at address zero and the upper half of the first 64 KB is fenced off. With remap set, the SRAM fills the whole first 64 KB. Both memories can always be reached through fixed alias windows, whatever the remap input says.

Addresses that are not decoded fall into two classes. The fenced part of the low window is restricted: an access there raises a bus error, which goes back to whichever master issued it. Every other address that no region covers is reserved: the access completes with no effect and no error, and the block flags it as a no-op. The decode is purely combinational. A master or interconnect samples the outputs in the same cycle as the address phase.

Top module: `mem_map_decode`

## Requirements
- R1: While `valid` is low, `sel` is 3'b000, `bus_err` and `nop` are 0, and `offset` is 0, whatever `addr` and `remap` hold.
- R2: With `remap`=0, an address in 0x0000_0000–0x0000_7FFF selects the ROM (`sel`=3'b001, bit 0 = ROM), with `offset` = addr[14:0].
- R3: With `remap`=0, an address in 0x0000_8000–0x0000_FFFF raises `bus_err`=1, with `sel`=0 and `nop`=0.
- R4: With `remap`=1, an address in 0x0000_0000–0x0000_FFFF selects the SRAM (`sel`=3'b010, bit 1 = SRAM), with `offset` = addr[15:0].
- R5: An address in 0x0040_0000–0x0040_7FFF selects the ROM for either value of `remap`, with `offset` = addr[14:0].
- R6: An address in 0x0080_0000–0x0080_FFFF selects the SRAM for either value of `remap`, with `offset` = addr[15:0].
- R7: An address in 0xFFFF_0000–0xFFFF_FFFF selects the peripheral space (`sel`=3'b100, bit 2 = peripherals), with `offset` = addr[15:0].
- R8: With `valid` high, any address outside the windows of R2–R7 gives `nop`=1, `bus_err`=0, `sel`=0 and `offset`=0.
- R9: With `valid` high, exactly one of the three `sel` bits, `bus_err` and `nop` is 1. The outputs follow a change of `remap` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 32 | Bus address of the current access |
| valid | input | 1 | Access strobe; decode outputs are active only while high |
| remap | input | 1 | Chooses the low-window map: 0 = ROM at zero, 1 = SRAM at zero |
| sel | output | 3 | One-hot target: bit 0 ROM, bit 1 SRAM, bit 2 peripherals |
| offset | output | 16 | Address within the selected region, masked to its size |
| bus_err | output | 1 | Access hit restricted space and must be answered with an error |
| nop | output | 1 | Access hit reserved space and completes with no effect |

## Verification
A change of the remap input and an access to the low window can fall in the same cycle. The decoder has to resolve the access against the new map, with no cycle of lag. The bench holds the address at 0x0000_8000 and flips remap between two samples. It judges that the result turns from a bus error into an SRAM select with offset 0x8000 in that same cycle, and back again when remap returns to 0. The vector table also puts the restricted and reserved classes side by side at their edges (0x0000_7FFF/0x0000_8000, 0x0040_7FFF/0x0040_8000, 0x0000_FFFF/0x0001_0000), so that an error cannot leak into reserved space and a no-op cannot leak into restricted space.

// File: rtl/mem_map_decode.sv
module mem_map_decode #(
  parameter int          ROM_AW     = 15,
  parameter int          SRAM_AW    = 16,
  parameter int          PERIPH_AW  = 16,
  parameter logic [31:0] ROM_ALIAS  = 32'h0040_0000,
  parameter logic [31:0] SRAM_ALIAS = 32'h0080_0000,
  parameter logic [31:0] PERIPH_BASE = 32'hFFFF_0000,
  localparam int OFS_W = (ROM_AW > SRAM_AW) ?
                         ((ROM_AW > PERIPH_AW) ? ROM_AW : PERIPH_AW) :
                         ((SRAM_AW > PERIPH_AW) ? SRAM_AW : PERIPH_AW)
) (
  input  logic [31:0]      addr,
  input  logic             valid,
  input  logic             remap,
  output logic [2:0]       sel,
  output logic [OFS_W-1:0] offset,
  output logic             bus_err,
  output logic             nop
);

  logic low_rom_win, low_sram_win;
  logic rom_alias_hit, sram_alias_hit, periph_hit;
  logic rom_hit, sram_hit, restricted_hit;

  assign low_rom_win    = (addr >> ROM_AW)  == 32'd0;
  assign low_sram_win   = (addr >> SRAM_AW) == 32'd0;
  assign rom_alias_hit  = (addr >> ROM_AW)    == (ROM_ALIAS  >> ROM_AW);
  assign sram_alias_hit = (addr >> SRAM_AW)   == (SRAM_ALIAS >> SRAM_AW);
  assign periph_hit     = (addr >> PERIPH_AW) == (PERIPH_BASE >> PERIPH_AW);

  assign rom_hit        = (!remap && low_rom_win) || rom_alias_hit;
  assign sram_hit       = (remap && low_sram_win) || sram_alias_hit;
  assign restricted_hit = !remap && low_sram_win && !low_rom_win;

  always_comb begin
    sel     = 3'b000;
    offset  = '0;
    bus_err = 1'b0;
    nop     = 1'b0;
    if (valid) begin
      if (rom_hit) begin
        sel    = 3'b001;
        offset = OFS_W'(addr[ROM_AW-1:0]);
      end else if (sram_hit) begin
        sel    = 3'b010;
        offset = OFS_W'(addr[SRAM_AW-1:0]);
      end else if (periph_hit) begin
        sel    = 3'b100;
        offset = OFS_W'(addr[PERIPH_AW-1:0]);
      end else if (restricted_hit) begin
        bus_err = 1'b1;
      end else begin
        nop = 1'b1;
      end
    end
  end

endmodule

module mem_map_decode_chk #(
  parameter int ROM_AW  = 15,
  parameter int SRAM_AW = 16,
  parameter int PERIPH_AW = 16,
  parameter int OFS_W   = 16
) (
  input logic [31:0]      addr,
  input logic             valid,
  input logic             remap,
  input logic [2:0]       sel,
  input logic [OFS_W-1:0] offset,
  input logic             bus_err,
  input logic             nop
);

  always_comb begin
    if (!valid)
      a_r1_idle_quiet: assert (sel == 3'b000 && !bus_err && !nop && offset == '0);
    if (valid)
      a_r9_one_outcome: assert ($countones({sel, bus_err, nop}) == 1);
    if (bus_err)
      a_r3_err_only_fenced: assert (!remap && (addr >> SRAM_AW) == 32'd0 && addr[ROM_AW]);
    if (valid && !remap && (addr >> ROM_AW) == 32'd0)
      a_r2_rom_at_zero: assert (sel == 3'b001 && offset == OFS_W'(addr[ROM_AW-1:0]));
    if (valid && remap && (addr >> SRAM_AW) == 32'd0)
      a_r4_sram_at_zero: assert (sel == 3'b010 && offset == OFS_W'(addr[SRAM_AW-1:0]));
    if (sel[2])
      a_r7_periph_offset: assert (offset == OFS_W'(addr[PERIPH_AW-1:0]));
    if (nop)
      a_r8_nop_no_offset: assert (offset == '0 && !bus_err);
  end

endmodule

bind mem_map_decode mem_map_decode_chk #(
  .ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW), .PERIPH_AW(PERIPH_AW), .OFS_W(OFS_W)
) u_chk (
  .addr(addr), .valid(valid), .remap(remap), .sel(sel),
  .offset(offset), .bus_err(bus_err), .nop(nop)
);

// File: tb/mem_map_decode_bench.sv
module mem_map_decode_bench;

  logic        clk = 1'b0;
  logic [31:0] addr;
  logic        valid;
  logic        remap;
  logic [2:0]  sel;
  logic [15:0] offset;
  logic        bus_err;
  logic        nop;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  mem_map_decode u_mem_map_decode (
    .addr(addr), .valid(valid), .remap(remap), .sel(sel),
    .offset(offset), .bus_err(bus_err), .nop(nop)
  );

  // {remap, addr, sel, err, nop, offset}
  localparam int NV = 19;
  localparam logic [53:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 3'b001, 1'b0, 1'b0, 16'h0000},  // R2
    {1'b0, 32'h0000_7FFF, 3'b001, 1'b0, 1'b0, 16'h7FFF},  // R2
    {1'b0, 32'h0000_8000, 3'b000, 1'b1, 1'b0, 16'h0000},  // R3
    {1'b0, 32'h0000_FFFF, 3'b000, 1'b1, 1'b0, 16'h0000},  // R3
    {1'b1, 32'h0000_0000, 3'b010, 1'b0, 1'b0, 16'h0000},  // R4
    {1'b1, 32'h0000_FFFF, 3'b010, 1'b0, 1'b0, 16'hFFFF},  // R4
    {1'b1, 32'h0000_8000, 3'b010, 1'b0, 1'b0, 16'h8000},  // R4
    {1'b0, 32'h0040_0000, 3'b001, 1'b0, 1'b0, 16'h0000},  // R5
    {1'b1, 32'h0040_7FFF, 3'b001, 1'b0, 1'b0, 16'h7FFF},  // R5
    {1'b1, 32'h0040_8000, 3'b000, 1'b0, 1'b1, 16'h0000},  // R8
    {1'b0, 32'h0080_0000, 3'b010, 1'b0, 1'b0, 16'h0000},  // R6
    {1'b0, 32'h0080_FFFF, 3'b010, 1'b0, 1'b0, 16'hFFFF},  // R6
    {1'b1, 32'h0081_0000, 3'b000, 1'b0, 1'b1, 16'h0000},  // R8
    {1'b0, 32'hFFFF_0000, 3'b100, 1'b0, 1'b0, 16'h0000},  // R7
    {1'b1, 32'hFFFF_FFFF, 3'b100, 1'b0, 1'b0, 16'hFFFF},  // R7
    {1'b0, 32'hFFFE_FFFF, 3'b000, 1'b0, 1'b1, 16'h0000},  // R8
    {1'b0, 32'h0001_0000, 3'b000, 1'b0, 1'b1, 16'h0000},  // R8
    {1'b1, 32'h0001_0000, 3'b000, 1'b0, 1'b1, 16'h0000},  // R8
    {1'b0, 32'h003F_FFFF, 3'b000, 1'b0, 1'b1, 16'h0000}   // R8
  };

  task automatic check(input string req, input logic [2:0] es, input logic ee,
                       input logic en, input logic [15:0] eo);
    n_checks++;
    if (sel !== es || bus_err !== ee || nop !== en || offset !== eo) begin
      n_fail++;
      $display("FAIL %s addr=%h remap=%b: got sel=%b err=%b nop=%b off=%h, exp sel=%b err=%b nop=%b off=%h",
               req, addr, remap, sel, bus_err, nop, offset, es, ee, en, eo);
    end
    if (valid && $countones({sel, bus_err, nop}) != 1) begin
      n_fail++;
      $display("FAIL R9 addr=%h: got %0d active outcomes, exp 1", addr,
               $countones({sel, bus_err, nop}));
    end
  endtask

  task automatic apply(input logic v, input logic r, input logic [31:0] a);
    @(posedge clk);
    valid = v; remap = r; addr = a;
    @(negedge clk);
  endtask

  initial begin
    valid = 1'b0; remap = 1'b0; addr = '0;
    @(negedge clk);
    check("R1", 3'b000, 1'b0, 1'b0, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VEC[i][53], VEC[i][52:21]);
      check("R2-R8 table", VEC[i][20:18], VEC[i][17], VEC[i][16], VEC[i][15:0]);
    end

    // R1: idle strobe hides every region, including restricted and peripheral
    apply(1'b0, 1'b0, 32'h0000_8000); check("R1", 3'b000, 1'b0, 1'b0, 16'h0000);
    apply(1'b0, 1'b1, 32'hFFFF_1234); check("R1", 3'b000, 1'b0, 1'b0, 16'h0000);
    apply(1'b0, 1'b0, 32'h0000_0123); check("R1", 3'b000, 1'b0, 1'b0, 16'h0000);

    // R9: remap flips with the address held; result follows in the same cycle
    apply(1'b1, 1'b0, 32'h0000_8000); check("R9", 3'b000, 1'b1, 1'b0, 16'h0000);
    remap = 1'b1; #1;                 check("R9", 3'b010, 1'b0, 1'b0, 16'h8000);
    remap = 1'b0; #1;                 check("R9", 3'b000, 1'b1, 1'b0, 16'h0000);
    // R2 vs R4 at a mid-window address
    apply(1'b1, 1'b0, 32'h0000_1234); check("R2", 3'b001, 1'b0, 1'b0, 16'h1234);
    remap = 1'b1; #1;                 check("R4", 3'b010, 1'b0, 1'b0, 16'h1234);
    // R5/R6: aliases ignore remap
    apply(1'b1, 1'b0, 32'h0040_4321); check("R5", 3'b001, 1'b0, 1'b0, 16'h4321);
    apply(1'b1, 1'b1, 32'h0080_ABCD); check("R6", 3'b010, 1'b0, 1'b0, 16'hABCD);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule